// File: doc/BRIEF.md
# Up/Down Timer with Buffered Compare Outputs

This block is a 16-bit counter whose advance is gated by a selectable count enable. The enable is one of four taps of a free-running prescaler, a pulse on every clock, or a one-cycle pulse made from a chosen edge of an asynchronous external count input. When no source is selected, the counter freezes and raises no events. The counter either counts up and wraps to zero after TOP, or runs a dual slope: up to TOP, then down to zero, then up again. TOP is one of four fixed values or a value held in a writable register.

Two compare channels each hold a pending value and an active value. The active value is the one compared with the count. With buffering on, a written value waits in the pending register until the counter leaves TOP. With buffering off, it takes effect on the write. A match on a channel sets that channel's flag and drives its waveform pin with a hold, toggle, set or clear action. An overflow flag marks the end of each counting period. Every flag is cleared by writing a one to it. A single interrupt line reports any flag whose mask bit is set.

Top module: `updn_timer16`

## Requirements
- R1: After reset the count is 0, the direction is up, all flags, both waveform pins and the interrupt line are 0, and both active compare values are 0xFFFF.
- R2: `clk_sel` picks the count enable: 0 stops the counter with no events, 1 advances it on every clock, and 2, 3, 4, 5 advance it once every 8, 64, 256 and 1024 clocks, when the low 3, 6, 8 or 10 bits of a free-running prescaler counter (cleared by reset) are all ones.
- R3: `clk_sel` 7 counts rising edges and 6 counts falling edges of `ext_cnt_in`. The input passes two synchronizing flops and one edge-detect flop, so the count changes on the third clock edge after the edge is first sampled, once per input edge.
- R4: With `updown` at 0, each enabled count adds one until the count reaches or exceeds TOP. The next enabled count then loads 0 and sets the overflow flag (`flags[0]`).
- R5: With `top_use_reg` at 0, TOP is 0x00FF, 0x01FF, 0x03FF or 0xFFFF for `top_fix_sel` 0, 1, 2 or 3. With `top_use_reg` at 1, TOP is the register loaded by `top_wr`/`top_wdata`, which is 0xFFFF after reset.
- R6: With `updown` at 1, the counter climbs to TOP, turns and counts down to 0, then turns upward again. `count_down` is 1 while it descends. An enabled count at 0 while descending sets the overflow flag and moves the count to 1.
- R7: `cnt_clr` sets the count to 0 and the direction to up on the next clock. It overrides a count enable in the same cycle, and that cycle raises no events.
- R8: A `cmp_wr[i]` strobe stores `cmp_wdata` in channel i's pending register. With `buf_en` at 0, the active value also takes the data on that clock. With `buf_en` at 1, the active value copies the pending register only on an enabled count taken at TOP while counting up.
- R9: An enabled count taken while the count equals channel i's active value sets `flags[1+i]` on that clock.
- R10: Channel i's 2-bit action field `wave_mode[2i+1:2i]` acts on each match. 0 holds the pin and 1 toggles it. 2 clears the pin, or sets it if the match happens while counting down in up/down mode. 3 sets the pin, or clears it if the match happens while counting down in up/down mode.
- R11: A 1 in `flag_clr` clears that flag bit. A set event in the same cycle wins over the clear. `irq` is 1 whenever any flag bit and its `irq_mask` bit are both 1.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| clk_sel | input | 3 | Count enable source code |
| ext_cnt_in | input | 1 | Asynchronous external count input |
| cnt_clr | input | 1 | Clear count and direction |
| updown | input | 1 | 1 = dual-slope counting, 0 = wrap at TOP |
| top_use_reg | input | 1 | 1 = TOP from register, 0 = fixed TOP |
| top_fix_sel | input | 2 | Fixed TOP choice |
| top_wr | input | 1 | Load TOP register |
| top_wdata | input | 16 | TOP register data |
| buf_en | input | 1 | Compare double buffering enable |
| cmp_wr | input | 2 | Per-channel compare write strobe |
| cmp_wdata | input | 16 | Compare write data |
| wave_mode | input | 4 | Per-channel 2-bit match action |
| flag_clr | input | 3 | Write-one-to-clear for the flags |
| irq_mask | input | 3 | Interrupt mask per flag |
| cnt_q | output | 16 | Current count |
| count_down | output | 1 | 1 while counting down |
| wave_out | output | 2 | Waveform pins |
| flags | output | 3 | Bit 0 overflow, bits 1..2 channel matches |
| irq | output | 1 | Masked OR of the flags |

## Verification
Some rules are checked by the assertions on every clock. A frozen count holds its value when no enable arrives. A clear yields zero. An enabled count below TOP in an upward phase adds exactly one. A descent that reaches zero turns upward. Each set event leaves its flag high, and an uncleared flag stays high. An active compare value holds while buffering keeps it, and takes written data at once when buffering is off. Other behaviour shows only across whole scenarios, where a cycle-by-cycle reference model feeds a scoreboard. This covers prescaler and edge timing, the dual-slope waveform shapes, the point at which a buffered value takes effect, wrap points for each TOP choice, and the interplay between clearing a flag and setting it.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

   typedef enum logic [2:0] {
      CS_STOP     = 3'd0,
      CS_EVERY    = 3'd1,
      CS_DIV_A    = 3'd2,
      CS_DIV_B    = 3'd3,
      CS_DIV_C    = 3'd4,
      CS_DIV_D    = 3'd5,
      CS_EXT_FALL = 3'd6,
      CS_EXT_RISE = 3'd7
   } clk_src_e;

   typedef enum logic [1:0] {
      WV_HOLD   = 2'd0,
      WV_TOGGLE = 2'd1,
      WV_CLR    = 2'd2,
      WV_SET    = 2'd3
   } wave_act_e;

   localparam int unsigned N_TAPS = 4;
   localparam int unsigned N_FIX  = 4;

endpackage

// File: rtl/tmr_clk_sel.sv
module tmr_clk_sel
   import tmr_pkg::*;
#(
   parameter int unsigned PRE_W = 10,
   parameter int unsigned TAP_LOG2 [N_TAPS] = '{3, 6, 8, 10}
) (
   input  logic       clk,
   input  logic       rst_n,
   input  logic [2:0] sel,
   input  logic       ext_in,
   output logic       tick
);

   logic [PRE_W-1:0]  pre_q;
   logic [N_TAPS-1:0] tap_hit;
   logic              sync1_q, sync2_q, prev_q;
   logic              ext_rise, ext_fall;

   for (genvar i = 0; i < N_TAPS; i++) begin : g_tap
      if (TAP_LOG2[i] < 1 || TAP_LOG2[i] > PRE_W) begin : g_bad
         $error("tmr_clk_sel: tap %0d outside prescaler width", i);
      end
      assign tap_hit[i] = &pre_q[TAP_LOG2[i]-1:0];
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pre_q   <= '0;
         sync1_q <= 1'b0;
         sync2_q <= 1'b0;
         prev_q  <= 1'b0;
      end else begin
         pre_q   <= pre_q + 1'b1;
         sync1_q <= ext_in;
         sync2_q <= sync1_q;
         prev_q  <= sync2_q;
      end
   end

   assign ext_rise = sync2_q & ~prev_q;
   assign ext_fall = ~sync2_q & prev_q;

   always_comb begin
      unique case (clk_src_e'(sel))
         CS_STOP:     tick = 1'b0;
         CS_EVERY:    tick = 1'b1;
         CS_DIV_A:    tick = tap_hit[0];
         CS_DIV_B:    tick = tap_hit[1];
         CS_DIV_C:    tick = tap_hit[2];
         CS_DIV_D:    tick = tap_hit[3];
         CS_EXT_FALL: tick = ext_fall;
         CS_EXT_RISE: tick = ext_rise;
         default:     tick = 1'b0;
      endcase
   end

   // R2: a stopped source never yields a count enable
   assert_stop_no_tick_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (sel == 3'd0) |-> !tick);

   // R3: an external edge pulse lasts one cycle
   assert_ext_pulse_R3: assert property (@(posedge clk) disable iff (!rst_n)
      ext_rise |=> !ext_rise);

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
   parameter int unsigned W = 16
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         clr,
   input  logic         updown,
   input  logic [W-1:0] top_val,
   output logic [W-1:0] cnt_q,
   output logic         dir_down,
   output logic         top_evt,
   output logic         ovf_evt
);

   logic         dir_q;
   logic [W-1:0] cnt_d;
   logic         dir_d;
   logic         at_top, at_bot;

   if (W < 2) begin : g_bad_w
      $error("tmr_counter: width must be at least 2");
   end

   assign at_top  = (cnt_q >= top_val);
   assign at_bot  = (cnt_q == '0);
   assign top_evt = step && !dir_q && at_top;
   assign ovf_evt = updown ? (step && dir_q && at_bot) : top_evt;

   always_comb begin
      cnt_d = cnt_q;
      dir_d = dir_q;
      if (clr) begin
         cnt_d = '0;
         dir_d = 1'b0;
      end else if (step) begin
         if (!updown) begin
            dir_d = 1'b0;
            cnt_d = at_top ? '0 : cnt_q + 1'b1;
         end else if (!dir_q) begin
            if (!at_top) begin
               cnt_d = cnt_q + 1'b1;
            end else if (top_val == '0) begin
               cnt_d = '0;
            end else begin
               cnt_d = cnt_q - 1'b1;
               dir_d = 1'b1;
            end
         end else begin
            if (at_bot) begin
               cnt_d = W'(1);
               dir_d = 1'b0;
            end else begin
               cnt_d = cnt_q - 1'b1;
            end
         end
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         dir_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         dir_q <= dir_d;
      end
   end

   assign dir_down = dir_q;

   // R2: no enable and no clear leaves the count alone
   assert_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (!step && !clr) |=> (cnt_q == $past(cnt_q)));

   // R7: clear lands on zero counting up
   assert_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
      clr |=> (cnt_q == '0 && !dir_q));

   // R4: an upward step below TOP adds exactly one
   assert_step_up_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && !dir_q && (cnt_q < top_val)) |=> (cnt_q == W'($past(cnt_q) + 1'b1)));

   // R6: descent reaching zero turns upward
   assert_turn_bottom_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (step && !clr && updown && dir_q && cnt_q == '0) |=> (!dir_q && cnt_q == W'(1)));

endmodule

// File: rtl/tmr_cmp_chan.sv
module tmr_cmp_chan
   import tmr_pkg::*;
#(
   parameter int unsigned W = 16,
   parameter logic [W-1:0] RST_CMP = '1
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         step,
   input  logic         wr,
   input  logic [W-1:0] wdata,
   input  logic         buf_en,
   input  logic         load_evt,
   input  logic [W-1:0] cnt,
   input  logic         dir_down,
   input  logic         updown,
   input  logic [1:0]   mode,
   output logic         match_evt,
   output logic         wave
);

   logic [W-1:0] pend_q;
   logic [W-1:0] act_q;
   logic         wave_d;
   logic         falling_leg;

   assign match_evt   = step && (cnt == act_q);
   assign falling_leg = updown && dir_down;

   always_comb begin
      wave_d = wave;
      if (match_evt) begin
         unique case (wave_act_e'(mode))
            WV_HOLD:   wave_d = wave;
            WV_TOGGLE: wave_d = ~wave;
            WV_CLR:    wave_d = falling_leg;
            WV_SET:    wave_d = ~falling_leg;
            default:   wave_d = wave;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_q <= RST_CMP;
         act_q  <= RST_CMP;
         wave   <= 1'b0;
      end else begin
         wave <= wave_d;
         if (wr) begin
            pend_q <= wdata;
         end
         if (wr && !buf_en) begin
            act_q <= wdata;
         end else if (buf_en && load_evt) begin
            act_q <= pend_q;
         end
      end
   end

   // R8: unbuffered write takes effect on its clock
   assert_direct_load_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (wr && !buf_en) |=> (act_q == $past(wdata)));

   // R8: buffered active value waits for TOP
   assert_buffer_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (buf_en && !load_evt) |=> (act_q == $past(act_q)));

   // R10: pin moves only on a match
   assert_wave_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !match_evt |=> (wave == $past(wave)));

endmodule

// File: rtl/updn_timer16.sv
module updn_timer16
   import tmr_pkg::*;
#(
   parameter int unsigned W = 16,
   parameter int unsigned N_CMP = 2,
   parameter int unsigned PRE_W = 10,
   parameter int unsigned TAP_LOG2 [N_TAPS] = '{3, 6, 8, 10},
   parameter logic [W-1:0] TOP_FIX [N_FIX] = '{16'h00FF, 16'h01FF, 16'h03FF, 16'hFFFF},
   localparam int unsigned NF = N_CMP + 1
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [2:0]         clk_sel,
   input  logic               ext_cnt_in,
   input  logic               cnt_clr,
   input  logic               updown,
   input  logic               top_use_reg,
   input  logic [1:0]         top_fix_sel,
   input  logic               top_wr,
   input  logic [W-1:0]       top_wdata,
   input  logic               buf_en,
   input  logic [N_CMP-1:0]   cmp_wr,
   input  logic [W-1:0]       cmp_wdata,
   input  logic [2*N_CMP-1:0] wave_mode,
   input  logic [NF-1:0]      flag_clr,
   input  logic [NF-1:0]      irq_mask,
   output logic [W-1:0]       cnt_q,
   output logic               count_down,
   output logic [N_CMP-1:0]   wave_out,
   output logic [NF-1:0]      flags,
   output logic               irq
);

   logic             tick, step;
   logic [W-1:0]     top_reg_q;
   logic [W-1:0]     top_val;
   logic             top_evt, ovf_evt;
   logic [N_CMP-1:0] match_evt;
   logic [NF-1:0]    set_evt;

   if (N_CMP < 1) begin : g_bad_n
      $error("updn_timer16: at least one compare channel required");
   end

   tmr_clk_sel #(
      .PRE_W    (PRE_W),
      .TAP_LOG2 (TAP_LOG2)
   ) u_clk_sel (
      .clk    (clk),
      .rst_n  (rst_n),
      .sel    (clk_sel),
      .ext_in (ext_cnt_in),
      .tick   (tick)
   );

   assign step = tick & ~cnt_clr;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         top_reg_q <= '1;
      end else if (top_wr) begin
         top_reg_q <= top_wdata;
      end
   end

   assign top_val = top_use_reg ? top_reg_q : TOP_FIX[top_fix_sel];

   tmr_counter #(
      .W (W)
   ) u_counter (
      .clk      (clk),
      .rst_n    (rst_n),
      .step     (step),
      .clr      (cnt_clr),
      .updown   (updown),
      .top_val  (top_val),
      .cnt_q    (cnt_q),
      .dir_down (count_down),
      .top_evt  (top_evt),
      .ovf_evt  (ovf_evt)
   );

   for (genvar i = 0; i < N_CMP; i++) begin : g_chan
      tmr_cmp_chan #(
         .W (W)
      ) u_chan (
         .clk       (clk),
         .rst_n     (rst_n),
         .step      (step),
         .wr        (cmp_wr[i]),
         .wdata     (cmp_wdata),
         .buf_en    (buf_en),
         .load_evt  (top_evt),
         .cnt       (cnt_q),
         .dir_down  (count_down),
         .updown    (updown),
         .mode      (wave_mode[2*i +: 2]),
         .match_evt (match_evt[i]),
         .wave      (wave_out[i])
      );
   end

   assign set_evt = {match_evt, ovf_evt};

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         flags <= '0;
      end else begin
         flags <= (flags & ~flag_clr) | set_evt;
      end
   end

   assign irq = |(flags & irq_mask);

   for (genvar f = 0; f < NF; f++) begin : g_flag_chk
      // R11: a flag stays up until a clear
      assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rst_n)
         (flags[f] && !flag_clr[f]) |=> flags[f]);
      // R9: an event always lands in its flag, even against a clear
      assert_flag_set_R9: assert property (@(posedge clk) disable iff (!rst_n)
         set_evt[f] |=> flags[f]);
   end

endmodule

// File: tb/updn_timer16_tb.sv
module updn_timer16_tb_top;

   localparam int W = 16;

   typedef struct {
      logic [W-1:0] cnt;
      logic         dn;
      logic [1:0]   wave;
      logic [2:0]   flg;
      string        tag;
   } exp_t;

   logic         clk = 1'b0;
   logic         rst_n = 1'b0;
   logic [2:0]   clk_sel = '0;
   logic         ext_cnt_in = 1'b0;
   logic         cnt_clr = 1'b0;
   logic         updown = 1'b0;
   logic         top_use_reg = 1'b0;
   logic [1:0]   top_fix_sel = '0;
   logic         top_wr = 1'b0;
   logic [W-1:0] top_wdata = '0;
   logic         buf_en = 1'b0;
   logic [1:0]   cmp_wr = '0;
   logic [W-1:0] cmp_wdata = '0;
   logic [3:0]   wave_mode = '0;
   logic [2:0]   flag_clr = '0;
   logic [2:0]   irq_mask = '0;
   logic [W-1:0] cnt_q;
   logic         count_down;
   logic [1:0]   wave_out;
   logic [2:0]   flags;
   logic         irq;

   int    n_chk = 0;
   int    n_fail = 0;
   int    cyc = 0;
   string phase = "R1";
   exp_t  sb_q[$];

   always #2.5 clk = ~clk;

   updn_timer16 dut_i (
      .clk (clk), .rst_n (rst_n), .clk_sel (clk_sel), .ext_cnt_in (ext_cnt_in),
      .cnt_clr (cnt_clr), .updown (updown), .top_use_reg (top_use_reg),
      .top_fix_sel (top_fix_sel), .top_wr (top_wr), .top_wdata (top_wdata),
      .buf_en (buf_en), .cmp_wr (cmp_wr), .cmp_wdata (cmp_wdata),
      .wave_mode (wave_mode), .flag_clr (flag_clr), .irq_mask (irq_mask),
      .cnt_q (cnt_q), .count_down (count_down), .wave_out (wave_out),
      .flags (flags), .irq (irq)
   );

   // reference model state, built from the requirements
   logic [9:0]   m_pre;
   logic         m_s1, m_s2, m_s3;
   logic [W-1:0] m_cnt, m_topreg;
   logic         m_dir;
   logic [W-1:0] m_act [2];
   logic [W-1:0] m_pend [2];
   logic [1:0]   m_wave;
   logic [2:0]   m_flg;

   function automatic logic [W-1:0] fixed_top(input logic [1:0] s);
      case (s)
         2'd0: return 16'h00FF;
         2'd1: return 16'h01FF;
         2'd2: return 16'h03FF;
         default: return 16'hFFFF;
      endcase
   endfunction

   function automatic logic tap(input logic [9:0] p, input int n);
      logic [9:0] m;
      m = 10'((1 << n) - 1);
      return (p & m) == m;
   endfunction

   // driver side of the scoreboard: the model pushes one expected item per clock
   always @(posedge clk) begin
      logic t, st, topev, ovf, n_dir;
      logic [W-1:0] tp, n_cnt;
      logic [1:0] mt, n_wave;
      exp_t e;
      if (!rst_n) begin
         m_pre = '0; m_s1 = 0; m_s2 = 0; m_s3 = 0;
         m_cnt = '0; m_dir = 0; m_topreg = '1;
         m_act[0] = '1; m_act[1] = '1; m_pend[0] = '1; m_pend[1] = '1;
         m_wave = '0; m_flg = '0;
      end else begin
         case (clk_sel)
            3'd0: t = 0;
            3'd1: t = 1;
            3'd2: t = tap(m_pre, 3);
            3'd3: t = tap(m_pre, 6);
            3'd4: t = tap(m_pre, 8);
            3'd5: t = tap(m_pre, 10);
            3'd6: t = !m_s2 && m_s3;
            default: t = m_s2 && !m_s3;
         endcase
         st = t && !cnt_clr;
         tp = top_use_reg ? m_topreg : fixed_top(top_fix_sel);
         topev = st && !m_dir && (m_cnt >= tp);
         ovf = updown ? (st && m_dir && m_cnt == 0) : topev;
         n_cnt = m_cnt; n_dir = m_dir;
         if (cnt_clr) begin
            n_cnt = 0; n_dir = 0;
         end else if (st) begin
            if (!updown) begin
               n_dir = 0;
               n_cnt = (m_cnt >= tp) ? 16'd0 : m_cnt + 16'd1;
            end else if (!m_dir) begin
               if (m_cnt < tp) n_cnt = m_cnt + 16'd1;
               else if (tp == 0) n_cnt = 0;
               else begin n_cnt = m_cnt - 16'd1; n_dir = 1; end
            end else if (m_cnt == 0) begin
               n_cnt = 16'd1; n_dir = 0;
            end else n_cnt = m_cnt - 16'd1;
         end
         n_wave = m_wave;
         for (int c = 0; c < 2; c++) begin
            mt[c] = st && (m_cnt == m_act[c]);
            if (mt[c]) begin
               case (wave_mode[2*c +: 2])
                  2'd1: n_wave[c] = ~m_wave[c];
                  2'd2: n_wave[c] = updown && m_dir;
                  2'd3: n_wave[c] = !(updown && m_dir);
                  default: ;
               endcase
            end
            if (cmp_wr[c] && !buf_en) m_act[c] = cmp_wdata;
            else if (buf_en && topev) m_act[c] = m_pend[c];
            if (cmp_wr[c]) m_pend[c] = cmp_wdata;
         end
         m_flg = (m_flg & ~flag_clr) | {mt, ovf};
         m_cnt = n_cnt; m_dir = n_dir; m_wave = n_wave;
         if (top_wr) m_topreg = top_wdata;
         m_pre = m_pre + 10'd1;
         m_s3 = m_s2; m_s2 = m_s1; m_s1 = ext_cnt_in;
         e.cnt = m_cnt; e.dn = m_dir; e.wave = m_wave; e.flg = m_flg; e.tag = phase;
         sb_q.push_back(e);
      end
   end

   // monitor side: compares one clock-phase after the edge
   always @(posedge clk) begin
      exp_t e;
      logic ex_irq;
      #1;
      cyc++;
      while (sb_q.size() > 0) begin
         e = sb_q.pop_front();
         ex_irq = |(e.flg & irq_mask);
         n_chk++;
         if (cnt_q !== e.cnt || count_down !== e.dn || wave_out !== e.wave ||
             flags !== e.flg || irq !== ex_irq) begin
            n_fail++;
            $display("FAIL %s: cnt/dn/wave/flags/irq actual %h/%b/%b/%b/%b expected %h/%b/%b/%b/%b",
                     e.tag, cnt_q, count_down, wave_out, flags, irq,
                     e.cnt, e.dn, e.wave, e.flg, ex_irq);
         end
      end
   end

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic cycles(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic write_cmp(input int ch, input logic [W-1:0] v);
      @(negedge clk);
      cmp_wr = 2'(1 << ch); cmp_wdata = v;
      @(negedge clk);
      cmp_wr = '0;
   endtask

   task automatic clear_count();
      @(negedge clk); cnt_clr = 1;
      @(negedge clk); cnt_clr = 0;
   endtask

   initial begin : watchdog
      wait (cyc > 190000);
      n_fail++;
      $display("FAIL watchdog: actual cycles %0d expected below 190000", cyc);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

   initial begin : stim
      logic [W-1:0] held;
      cycles(3);
      @(posedge clk); #1;
      // R1: reset values
      check(cnt_q == 0 && count_down == 0, "R1 count", cnt_q, 0);
      check(flags == 0 && wave_out == 0 && irq == 0, "R1 flags/wave/irq", {flags, wave_out, irq}, 0);
      @(negedge clk); rst_n = 1;

      // R2: stopped source holds the count
      phase = "R2 stop";
      cycles(20);
      @(posedge clk); #1;
      check(cnt_q == 0 && flags == 0, "R2 stop", cnt_q, 0);

      // R8 unbuffered, R4 wrap, R9 flags, R10 toggle/set, R11 clear/mask
      phase = "R8 direct";
      buf_en = 0;
      write_cmp(0, 16'd5);
      write_cmp(1, 16'd10);
      @(negedge clk); wave_mode = 4'b11_01; irq_mask = 3'b011;
      phase = "R4/R9/R10 up wrap";
      clk_sel = 1;
      cycles(300);
      phase = "R11 clear/irq";
      @(negedge clk); flag_clr = 3'b111;
      @(negedge clk); flag_clr = 3'b000;
      cycles(250);
      // R11: clear asserted for many cycles so it meets set events too
      @(negedge clk); flag_clr = 3'b010;
      cycles(260);
      @(negedge clk); flag_clr = 3'b000; irq_mask = 3'b100;
      cycles(40);

      // R5/R6/R10: register TOP, dual slope, clear-on-up / set-on-up
      phase = "R5/R6/R10 dual slope";
      @(negedge clk); top_wr = 1; top_wdata = 16'd40; top_use_reg = 1; updown = 1;
      wave_mode = 4'b10_11;
      @(negedge clk); top_wr = 0;
      clear_count();
      cycles(200);

      // R8: buffered values wait for TOP
      phase = "R8 buffered";
      @(negedge clk); buf_en = 1;
      write_cmp(0, 16'd20);
      write_cmp(1, 16'd33);
      cycles(150);

      // R7: clear in the middle of counting
      phase = "R7 clear";
      cycles(7);
      clear_count();
      @(posedge clk); #1;
      check(count_down == 0, "R7 direction", count_down, 0);
      cycles(30);

      // R2: prescaler taps
      @(negedge clk); updown = 0; top_use_reg = 0; top_fix_sel = 0; buf_en = 0;
      for (int s = 2; s <= 5; s++) begin
         phase = $sformatf("R2 prescale sel %0d", s);
         @(negedge clk); clk_sel = 3'(s);
         cycles(2200);
      end
      @(negedge clk); clk_sel = 0;
      held = cnt_q;
      cycles(25);
      @(posedge clk); #1;
      check(cnt_q == held, "R2 frozen", cnt_q, held);

      // R3: external edges, rising then falling
      for (int s = 7; s >= 6; s--) begin
         phase = $sformatf("R3 external sel %0d", s);
         @(negedge clk); clk_sel = 3'(s);
         for (int k = 0; k < 24; k++) begin
            cycles(k % 2 == 0 ? 4 : 7);
            ext_cnt_in = ~ext_cnt_in;
         end
         cycles(8);
      end

      // R5: remaining fixed TOP values in up mode
      @(negedge clk); clk_sel = 1; buf_en = 0;
      write_cmp(0, 16'h0100);
      write_cmp(1, 16'hFFF0);
      for (int s = 1; s <= 3; s++) begin
         phase = $sformatf("R5 fixed top %0d", s);
         @(negedge clk); top_fix_sel = 2'(s);
         clear_count();
         cycles(s == 3 ? 65600 : (s == 2 ? 1100 : 600));
      end

      @(negedge clk); clk_sel = 0;
      cycles(4);
      $display("  TB_RESULT checks=%0d failures=%0d", n_chk, n_fail);
      $finish;
   end

endmodule